// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits on the request path in front of a memory and decides which writes may reach the array. It keeps one reservation per execution context, where a context is a (CPU, thread) pair. A locked read, or load-linked, arms or re-arms the reservation of the issuing context. Every write that passes through is compared against all held reservations. A conditional write, or store-conditional, is let through only when its own context still holds a reservation on the same block.

Each operation is presented for one clock cycle. The write enable is combinational, so the memory sees the decision in the same cycle as the request. The reservation table and the store-conditional result register update at the clock edge that ends the operation. Address matching works on coarse blocks: the low `GRAN_BITS` address bits, four by default, are ignored.

Top module: `llsc_resv_monitor`

## Requirements
- R1: Two addresses match when they agree in every bit above the low `GRAN_BITS` bits (16-byte blocks by default). The low bits never affect a match.
- R2: A read (`op_code` 2'b01) with `op_locked` high arms the reservation of its (CPU, thread) context with the block of `op_addr`. If that context already holds a reservation, the new block replaces the old one.
- R3: At the edge that ends any write (`op_code` 2'b10), every reservation on the written block is removed, in every context. This applies to plain writes, to successful conditional writes and to failed conditional writes.
- R4: A conditional write (write with `op_locked` high) succeeds only if the issuing context holds a reservation on the same block at that cycle. A reservation held by a different context does not count.
- R5: A plain write (`op_locked` low) drives `mem_we` high in the same cycle.
- R6: A failed conditional write keeps `mem_we` low.
- R7: After the edge that ends a conditional write, `sc_result` is 1 if the write succeeded and 0 if it failed. Plain writes, reads and idle cycles leave `sc_result` unchanged.
- R8: When no context holds a reservation, every conditional write fails.
- R9: Op codes 2'b00 and 2'b11, and reads, keep `mem_we` low. A read without `op_locked`, and an idle code with `op_locked` high, leave the reservations unchanged.
- R10: While `rst_n` is low, `sc_result` is 0 and all reservations are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 2 | Operation: 01 read, 10 write, 00/11 idle |
| op_locked | input | 1 | Marks a read as load-linked and a write as store-conditional |
| op_addr | input | ADDR_W | Physical address of the operation |
| op_cpu | input | CPU_W | Issuing CPU number, below NCPU |
| op_thr | input | THR_W | Issuing thread number, below NTHR |
| mem_we | output | 1 | Write enable towards memory, valid in the request cycle |
| sc_result | output | 1 | Outcome of the most recent conditional write |

## Verification
The properties take for granted that `op_cpu` is below NCPU and `op_thr` is below NTHR. An out-of-range pair would select no slot, and the arming property would then have no slot to observe. They also take for granted that the request fields are held steady across the rising edge, since `mem_we` is judged combinationally from them. The stimulus uses NCPU=4 and NTHR=2, so every code the ID fields can carry is a legal context. It changes inputs only on the falling edge and holds them through the following rising edge.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

   // Operation encodings carried on op_code
   localparam logic [1:0] OPC_IDLE  = 2'b00;
   localparam logic [1:0] OPC_READ  = 2'b01;
   localparam logic [1:0] OPC_WRITE = 2'b10;
   localparam logic [1:0] OPC_SPARE = 2'b11;

   // Bits needed to index n items, never less than one
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/llsc_ctx_decode.sv
module llsc_ctx_decode #(
   parameter int unsigned NCPU  = 4,
   parameter int unsigned NTHR  = 2,
   parameter int unsigned CPU_W = 2,
   parameter int unsigned THR_W = 1,
   localparam int unsigned NCTX = NCPU * NTHR
) (
   input  logic [CPU_W-1:0] cpu_i,
   input  logic [THR_W-1:0] thr_i,
   output logic [NCTX-1:0]  sel_o
);

   // One select line per (cpu, thread) context, slot index = cpu*NTHR + thr
   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      for (genvar t = 0; t < NTHR; t++) begin : g_thr
         assign sel_o[c*NTHR + t] = (cpu_i == CPU_W'(c)) && (thr_i == THR_W'(t));
      end
   end

endmodule

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
   parameter int unsigned TAG_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic [TAG_W-1:0] arm_tag_i,
   input  logic             kill_i,
   output logic             vld_o,
   output logic [TAG_W-1:0] tag_o
);

   // A load-linked and a write never coincide, so arm simply wins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         tag_o <= '0;
      end else if (arm_i) begin
         vld_o <= 1'b1;
         tag_o <= arm_tag_i;
      end else if (kill_i) begin
         vld_o <= 1'b0;
      end
   end

endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge #(
   parameter int unsigned NCTX  = 8,
   parameter int unsigned TAG_W = 28
) (
   input  logic                  is_wr_i,
   input  logic                  locked_i,
   input  logic [TAG_W-1:0]      op_tag_i,
   input  logic [NCTX-1:0]       ctx_sel_i,
   input  logic [NCTX-1:0]       slot_vld_i,
   input  logic [NCTX*TAG_W-1:0] slot_tag_i,
   output logic [NCTX-1:0]       kill_o,
   output logic                  sc_pass_o,
   output logic                  mem_we_o
);

   logic [NCTX-1:0] hit;
   logic            any_resv;
   logic            own_hit;

   // Block-address compare against every held reservation
   for (genvar i = 0; i < NCTX; i++) begin : g_cmp
      assign hit[i] = slot_vld_i[i] && (slot_tag_i[i*TAG_W +: TAG_W] == op_tag_i);
   end

   assign any_resv  = |slot_vld_i;
   assign own_hit   = |(hit & ctx_sel_i);
   assign sc_pass_o = is_wr_i && locked_i && any_resv && own_hit;
   assign kill_o    = {NCTX{is_wr_i}} & hit;
   assign mem_we_o  = is_wr_i && (!locked_i || sc_pass_o);

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
   import llsc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned GRAN_BITS = 4,
   parameter int unsigned NCPU      = 4,
   parameter int unsigned NTHR      = 2,
   localparam int unsigned CPU_W    = idx_width(NCPU),
   localparam int unsigned THR_W    = idx_width(NTHR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op_code,
   input  logic              op_locked,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [CPU_W-1:0]  op_cpu,
   input  logic [THR_W-1:0]  op_thr,
   output logic              mem_we,
   output logic              sc_result
);

   localparam int unsigned NCTX  = NCPU * NTHR;
   localparam int unsigned TAG_W = ADDR_W - GRAN_BITS;

   // Elaboration-time parameter checks
   if (GRAN_BITS >= ADDR_W) begin : g_bad_gran
      $error("GRAN_BITS must be below ADDR_W");
   end
   if (NCPU < 1 || NTHR < 1) begin : g_bad_ctx
      $error("NCPU and NTHR must be at least one");
   end

   logic [TAG_W-1:0]      op_tag;
   logic                  is_wr;
   logic                  is_sc;
   logic                  is_ll;
   logic [NCTX-1:0]       ctx_sel;
   logic [NCTX-1:0]       arm_vec;
   logic [NCTX-1:0]       kill_vec;
   logic [NCTX-1:0]       slot_vld;
   logic [NCTX*TAG_W-1:0] slot_tag_flat;
   logic                  sc_pass;

   // Block tag: drop the low granularity bits (R1)
   if (GRAN_BITS == 0) begin : g_tag_full
      assign op_tag = op_addr;
   end else begin : g_tag_coarse
      assign op_tag = op_addr[ADDR_W-1:GRAN_BITS];
   end

   assign is_wr   = (op_code == OPC_WRITE);
   assign is_sc   = is_wr && op_locked;
   assign is_ll   = (op_code == OPC_READ) && op_locked;
   assign arm_vec = {NCTX{is_ll}} & ctx_sel;

   llsc_ctx_decode #(
      .NCPU (NCPU),
      .NTHR (NTHR),
      .CPU_W(CPU_W),
      .THR_W(THR_W)
   ) u_dec (
      .cpu_i(op_cpu),
      .thr_i(op_thr),
      .sel_o(ctx_sel)
   );

   for (genvar i = 0; i < NCTX; i++) begin : g_slot
      llsc_resv_slot #(
         .TAG_W(TAG_W)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .arm_i    (arm_vec[i]),
         .arm_tag_i(op_tag),
         .kill_i   (kill_vec[i]),
         .vld_o    (slot_vld[i]),
         .tag_o    (slot_tag_flat[i*TAG_W +: TAG_W])
      );
   end

   llsc_sc_judge #(
      .NCTX (NCTX),
      .TAG_W(TAG_W)
   ) u_judge (
      .is_wr_i   (is_wr),
      .locked_i  (op_locked),
      .op_tag_i  (op_tag),
      .ctx_sel_i (ctx_sel),
      .slot_vld_i(slot_vld),
      .slot_tag_i(slot_tag_flat),
      .kill_o    (kill_vec),
      .sc_pass_o (sc_pass),
      .mem_we_o  (mem_we)
   );

   // Result bit moves only on conditional writes (R7)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sc_result <= 1'b0;
      end else if (is_sc) begin
         sc_result <= sc_pass;
      end
   end

endmodule

// File: rtl/llsc_resv_monitor_chk.sv
module llsc_resv_monitor_chk
   import llsc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned GRAN_BITS = 4,
   parameter int unsigned NCPU      = 4,
   parameter int unsigned NTHR      = 2,
   localparam int unsigned CPU_W    = idx_width(NCPU),
   localparam int unsigned THR_W    = idx_width(NTHR),
   localparam int unsigned NCTX     = NCPU * NTHR,
   localparam int unsigned TAG_W    = ADDR_W - GRAN_BITS
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            op_code,
   input logic                  op_locked,
   input logic [ADDR_W-1:0]     op_addr,
   input logic [CPU_W-1:0]      op_cpu,
   input logic [THR_W-1:0]      op_thr,
   input logic                  mem_we,
   input logic                  sc_result,
   input logic [NCTX-1:0]       slot_vld,
   input logic [NCTX*TAG_W-1:0] slot_tag_flat
);

   logic [TAG_W-1:0] c_tag;
   logic             c_wr;
   logic             c_sc;
   logic             c_ll;
   logic             c_idle;
   int unsigned      c_ctx;

   assign c_tag  = op_addr[ADDR_W-1:ADDR_W-TAG_W];
   assign c_wr   = (op_code == OPC_WRITE);
   assign c_sc   = c_wr && op_locked;
   assign c_ll   = (op_code == OPC_READ) && op_locked;
   assign c_idle = (op_code == OPC_IDLE) || (op_code == OPC_SPARE);
   assign c_ctx  = int'(op_cpu) * NTHR + int'(op_thr);

   p_plain_store_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (c_wr && !op_locked) |-> mem_we)
      else $error("plain write blocked");

   p_no_we_off_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !c_wr |-> !mem_we)
      else $error("write enable without a write");

   p_empty_table_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (c_sc && (slot_vld == '0)) |-> !mem_we)
      else $error("conditional write passed with empty table");

   p_result_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      c_sc |=> (sc_result == $past(mem_we)))
      else $error("result bit disagrees with write enable");

   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !c_sc |=> $stable(sc_result))
      else $error("result bit moved without a conditional write");

   p_idle_keeps_table_r9: assert property (@(posedge clk) disable iff (!rst_n)
      c_idle |=> ($stable(slot_vld) && $stable(slot_tag_flat)))
      else $error("idle cycle changed reservations");

   for (genvar i = 0; i < NCTX; i++) begin : g_slot_chk
      p_arm_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (c_ll && c_ctx == i) |=>
            (slot_vld[i] && slot_tag_flat[i*TAG_W +: TAG_W] == $past(c_tag)))
         else $error("load-linked did not arm its slot");

      p_write_kills_r3: assert property (@(posedge clk) disable iff (!rst_n)
         c_wr |=> !(slot_vld[i] && slot_tag_flat[i*TAG_W +: TAG_W] == $past(c_tag)))
         else $error("reservation survived a write to its block");
   end

endmodule

bind llsc_resv_monitor llsc_resv_monitor_chk #(
   .ADDR_W   (ADDR_W),
   .GRAN_BITS(GRAN_BITS),
   .NCPU     (NCPU),
   .NTHR     (NTHR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_code      (op_code),
   .op_locked    (op_locked),
   .op_addr      (op_addr),
   .op_cpu       (op_cpu),
   .op_thr       (op_thr),
   .mem_we       (mem_we),
   .sc_result    (sc_result),
   .slot_vld     (slot_vld),
   .slot_tag_flat(slot_tag_flat)
);

// File: tb/llsc_resv_monitor_test.sv
module llsc_resv_monitor_test;

   localparam int ADDR_W = 32;
   localparam int NVEC   = 25;
   localparam int VW     = 44;

   localparam logic [1:0] RD = 2'b01;
   localparam logic [1:0] WR = 2'b10;
   localparam logic [1:0] I0 = 2'b00;
   localparam logic [1:0] I3 = 2'b11;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [1:0]        op_code;
   logic              op_locked;
   logic [ADDR_W-1:0] op_addr;
   logic [1:0]        op_cpu;
   logic [0:0]        op_thr;
   logic              mem_we;
   logic              sc_result;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   llsc_resv_monitor #(
      .ADDR_W(ADDR_W), .GRAN_BITS(4), .NCPU(4), .NTHR(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_locked(op_locked),
      .op_addr(op_addr), .op_cpu(op_cpu), .op_thr(op_thr),
      .mem_we(mem_we), .sc_result(sc_result)
   );

   // {req[3:0], op[1:0], locked, addr[31:0], cpu[1:0], thr, exp_we, exp_sc_after}
   localparam logic [VW-1:0] VEC [0:NVEC-1] = '{
      {4'd8,  WR, 1'b1, 32'h100, 2'd0, 1'b0, 1'b0, 1'b0}, // R8 empty table
      {4'd2,  RD, 1'b1, 32'h100, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 arm (0,0)
      {4'd1,  WR, 1'b1, 32'h10C, 2'd0, 1'b0, 1'b1, 1'b1}, // R1 same block
      {4'd3,  WR, 1'b1, 32'h100, 2'd0, 1'b0, 1'b0, 1'b0}, // R3 consumed
      {4'd2,  RD, 1'b1, 32'h200, 2'd1, 1'b0, 1'b0, 1'b0}, // R2 arm (1,0)
      {4'd2,  RD, 1'b1, 32'h200, 2'd2, 1'b1, 1'b0, 1'b0}, // R2 arm (2,1)
      {4'd5,  WR, 1'b0, 32'h208, 2'd3, 1'b0, 1'b1, 1'b0}, // R5 plain write
      {4'd3,  WR, 1'b1, 32'h200, 2'd1, 1'b0, 1'b0, 1'b0}, // R3 killed
      {4'd3,  WR, 1'b1, 32'h200, 2'd2, 1'b1, 1'b0, 1'b0}, // R3 killed
      {4'd2,  RD, 1'b1, 32'h300, 2'd0, 1'b1, 1'b0, 1'b0}, // R2 arm (0,1)
      {4'd2,  RD, 1'b1, 32'h400, 2'd0, 1'b1, 1'b0, 1'b0}, // R2 replace
      {4'd2,  WR, 1'b1, 32'h300, 2'd0, 1'b1, 1'b0, 1'b0}, // R2 old block gone
      {4'd2,  WR, 1'b1, 32'h400, 2'd0, 1'b1, 1'b1, 1'b1}, // R2 new block holds
      {4'd7,  RD, 1'b1, 32'h500, 2'd1, 1'b1, 1'b0, 1'b1}, // R7 read keeps result
      {4'd6,  WR, 1'b1, 32'h500, 2'd2, 1'b0, 1'b0, 1'b0}, // R6 other context
      {4'd3,  WR, 1'b1, 32'h500, 2'd1, 1'b1, 1'b0, 1'b0}, // R3 failed SC killed
      {4'd2,  RD, 1'b1, 32'h600, 2'd3, 1'b1, 1'b0, 1'b0}, // R2 arm (3,1)
      {4'd9,  I3, 1'b1, 32'h600, 2'd3, 1'b1, 1'b0, 1'b0}, // R9 spare code
      {4'd9,  RD, 1'b0, 32'h600, 2'd3, 1'b1, 1'b0, 1'b0}, // R9 plain read
      {4'd9,  I0, 1'b1, 32'h600, 2'd3, 1'b1, 1'b0, 1'b0}, // R9 idle code
      {4'd4,  WR, 1'b1, 32'h600, 2'd3, 1'b1, 1'b1, 1'b1}, // R4 own context
      {4'd7,  WR, 1'b0, 32'h700, 2'd0, 1'b0, 1'b1, 1'b1}, // R7 plain keeps result
      {4'd2,  RD, 1'b1, 32'h800, 2'd2, 1'b0, 1'b0, 1'b1}, // R2 arm (2,0)
      {4'd1,  WR, 1'b1, 32'h810, 2'd2, 1'b0, 1'b0, 1'b0}, // R1 next block
      {4'd1,  WR, 1'b1, 32'h80F, 2'd2, 1'b0, 1'b1, 1'b1}  // R1 top byte of block
   };

   task automatic check(input string what, input int req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic drive(input logic [1:0] oc, input logic lk, input logic [31:0] a,
                        input logic [1:0] c, input logic t);
      op_code = oc; op_locked = lk; op_addr = a; op_cpu = c; op_thr = t;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0;
      drive(I0, 1'b0, 32'h0, 2'd0, 1'b0);
      repeat (3) @(posedge clk);
      #1;
      check("reset sc_result", 10, sc_result, 1'b0); // R10
      check("reset mem_we", 10, mem_we, 1'b0);       // R10
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NVEC; k++) begin
         logic [VW-1:0] v;
         v = VEC[k];
         @(negedge clk);
         drive(v[39:38], v[37], v[36:5], v[4:3], v[2]);
         #1;
         check($sformatf("vec %0d mem_we", k), int'(v[43:40]), mem_we, v[1]);
         @(posedge clk);
         #1;
         check($sformatf("vec %0d sc_result", k), int'(v[43:40]), sc_result, v[0]);
      end

      // R10: reset in mid-run drops result and reservations
      @(negedge clk);
      drive(RD, 1'b1, 32'h900, 2'd1, 1'b0);
      @(negedge clk);
      drive(I0, 1'b0, 32'h0, 2'd0, 1'b0);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check("mid reset sc_result", 10, sc_result, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(WR, 1'b1, 32'h900, 2'd1, 1'b0);
      #1;
      check("reservation cleared by reset", 10, mem_we, 1'b0);
      @(posedge clk);
      #1;
      check("post reset SC result", 10, sc_result, 1'b0);
      @(negedge clk);
      drive(I0, 1'b0, 32'h0, 2'd0, 1'b0);

      done = 1'b1;
      finish_run();
   end

endmodule